// File: doc/BRIEF.md
# Core Execution Mode Switch Controller

This controller picks the execution mode of a core that can run either as a wide out-of-order engine for a few threads or as a multithreaded in-order engine for many. While idle it compares the active-thread count against a threshold: a count of two or fewer calls for out-of-order mode, and anything above two calls for in-order mode. If the requested mode differs from the current one, the controller runs a fixed switching sequence and holds the busy output high so that fetch stays stalled.

The sequence has four steps:
1. Wait for the pipeline to report that it is empty.
2. Ask a register transfer engine to save the architectural state of the running threads.
3. Turn the renaming, out-of-order scheduling and load-queue units on or off to match the new mode.
4. Ask the same engine to restore the state of the threads that run next.

The restore loads the rename tables only when the target is out-of-order mode. The thread count is read once, when the switch begins. A count that changes during the sequence is acted on only after the controller returns to idle.

Top module: `mode_switch_ctrl`

## Requirements
- R1: After reset the mode output is out-of-order (1), all three unit enables are 1, busy is 0 and no transfer is requested.
- R2: While idle, a count of at most 2 selects out-of-order mode and a count above 2 selects in-order mode. For every count from 0 to 15, busy rises one cycle after the count is applied if and only if the selected mode differs from the current mode.
- R3: Busy stays 1 from the first cycle of a switch until the cycle in which the mode output takes its new value. A transfer request is never raised while busy is 0.
- R4: No save request (xfer_req=1, xfer_fill=0) is raised until pipe_empty has been seen high during the drain step. The save request appears one cycle after pipe_empty is sampled high.
- R5: A transfer request stays high with an unchanged direction until xfer_ack is sampled high. An xfer_ack that arrives while no request is pending has no effect on any output.
- R6: All three unit enables take the target mode's value (1 for out-of-order, 0 for in-order) in the cycle after the save is acknowledged. They change at no other time, and always while busy and no request is pending.
- R7: One cycle after the units step, a restore request (xfer_req=1, xfer_fill=1) is raised. While it is pending, rat_load is 1 only if the target is out-of-order mode.
- R8: The mode output takes the target value, and busy falls, in the cycle after the restore is acknowledged.
- R9: A count change during a switch does not alter that switch's target. After the return to idle the latest count is evaluated again, and a new switch starts one cycle later if the count calls for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| active_threads | input | 4 | Number of threads currently active |
| pipe_empty | input | 1 | Pipeline holds no in-flight instructions |
| xfer_ack | input | 1 | Register transfer engine completed the pending request |
| xfer_req | output | 1 | Transfer request to the register transfer engine |
| xfer_fill | output | 1 | Request direction: 0 = save to reserved storage, 1 = restore |
| rat_load | output | 1 | Restore also rebuilds the rename tables |
| rename_en | output | 1 | Renaming unit enable |
| ooo_sched_en | output | 1 | Out-of-order scheduler enable |
| ldq_en | output | 1 | Load queue enable |
| mode_ooo | output | 1 | Current mode: 1 = out-of-order, 0 = in-order |
| busy | output | 1 | Switch in progress; fetch must stall |

## Verification
The assertions assume that the transfer engine raises xfer_ack only after a request has been seen. They also assume that pipe_empty describes the real pipeline, because the controller never stops instruction delivery by itself. The stimulus sets inputs on the falling edge, keeps each acknowledge to a single cycle, and also drives stray acknowledges while idle and during the drain step to show that they are ignored. The count is swept over every value of its field, from both starting modes, and some switches change the count in the middle of the sequence.

// File: rtl/mode_sw_pkg.sv
package mode_sw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DRAIN = 3'd1,
        ST_SPILL = 3'd2,
        ST_UNITS = 3'd3,
        ST_FILL  = 3'd4
    } sw_state_e;

    typedef struct packed {
        sw_state_e state;
        logic      mode_ooo;
        logic      target_ooo;
        logic      units_on;
    } sw_regs_t;

endpackage

// File: rtl/mode_policy.sv
module mode_policy #(
    parameter int CNT_W     = 4,
    parameter int OOO_LIMIT = 2
) (
    input  logic [CNT_W-1:0] thread_cnt,
    output logic             want_ooo
);
    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(OOO_LIMIT);

    always_comb begin
        want_ooo = (thread_cnt <= LIMIT_V);
    end
endmodule

// File: rtl/switch_seq.sv
module switch_seq
    import mode_sw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic want_ooo,
    input  logic pipe_empty,
    input  logic xfer_ack,
    output logic xfer_req,
    output logic xfer_fill,
    output logic rat_load,
    output logic units_on,
    output logic mode_ooo,
    output logic busy
);
    sw_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (want_ooo != r_q.mode_ooo) begin
                    r_d.target_ooo = want_ooo;
                    r_d.state      = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (pipe_empty) r_d.state = ST_SPILL;
            end
            ST_SPILL: begin
                if (xfer_ack) begin
                    r_d.units_on = r_q.target_ooo;
                    r_d.state    = ST_UNITS;
                end
            end
            ST_UNITS: begin
                r_d.state = ST_FILL;
            end
            ST_FILL: begin
                if (xfer_ack) begin
                    r_d.mode_ooo = r_q.target_ooo;
                    r_d.state    = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state      <= ST_IDLE;
            r_q.mode_ooo   <= 1'b1;
            r_q.target_ooo <= 1'b1;
            r_q.units_on   <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        xfer_req  = (r_q.state == ST_SPILL) || (r_q.state == ST_FILL);
        xfer_fill = (r_q.state == ST_FILL);
        rat_load  = (r_q.state == ST_FILL) && r_q.target_ooo;
        units_on  = r_q.units_on;
        mode_ooo  = r_q.mode_ooo;
        busy      = (r_q.state != ST_IDLE);
    end

    // R3
    idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !xfer_req);

    // R4
    spill_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_fill && !$past(xfer_req)) |-> $past(pipe_empty));

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_fill)));

    // R6
    units_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(units_on) |-> (busy && !xfer_req && $past(xfer_req && xfer_ack)));

    // R7
    rat_only_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rat_load |-> (xfer_req && xfer_fill && units_on));

    // R8
    mode_on_fill_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_ooo) |-> ($past(xfer_req && xfer_fill && xfer_ack) && !busy));
endmodule

// File: rtl/mode_switch_ctrl.sv
module mode_switch_ctrl #(
    parameter int MAX_THREADS = 8,
    parameter int OOO_LIMIT   = 2,
    parameter int CNT_W       = $clog2(MAX_THREADS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] active_threads,
    input  logic             pipe_empty,
    input  logic             xfer_ack,
    output logic             xfer_req,
    output logic             xfer_fill,
    output logic             rat_load,
    output logic             rename_en,
    output logic             ooo_sched_en,
    output logic             ldq_en,
    output logic             mode_ooo,
    output logic             busy
);
    logic want_ooo;
    logic units_on;

    mode_policy #(
        .CNT_W    (CNT_W),
        .OOO_LIMIT(OOO_LIMIT)
    ) u_policy (
        .thread_cnt(active_threads),
        .want_ooo  (want_ooo)
    );

    switch_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .want_ooo  (want_ooo),
        .pipe_empty(pipe_empty),
        .xfer_ack  (xfer_ack),
        .xfer_req  (xfer_req),
        .xfer_fill (xfer_fill),
        .rat_load  (rat_load),
        .units_on  (units_on),
        .mode_ooo  (mode_ooo),
        .busy      (busy)
    );

    always_comb begin
        rename_en    = units_on;
        ooo_sched_en = units_on;
        ldq_en       = units_on;
    end

    // R6
    units_match_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (rename_en == mode_ooo && ldq_en == mode_ooo && ooo_sched_en == mode_ooo));
endmodule

// File: tb/sim_mode_switch_ctrl.sv
module sim_mode_switch_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] active_threads = 4'd1;
    logic       pipe_empty = 1'b0;
    logic       xfer_ack = 1'b0;
    logic       xfer_req, xfer_fill, rat_load, rename_en, ooo_sched_en, ldq_en, mode_ooo, busy;

    int n_chk = 0;
    int n_fail = 0;
    logic model_mode = 1'b1;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mode_switch_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .active_threads(active_threads),
        .pipe_empty(pipe_empty), .xfer_ack(xfer_ack), .xfer_req(xfer_req),
        .xfer_fill(xfer_fill), .rat_load(rat_load), .rename_en(rename_en),
        .ooo_sched_en(ooo_sched_en), .ldq_en(ldq_en), .mode_ooo(mode_ooo),
        .busy(busy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] units();
        return {rename_en, ooo_sched_en, ldq_en};
    endfunction

    // Runs a switch that has already started: busy was seen high at this negedge.
    task automatic run_switch(input logic tgt, input int drain_wait, input int ack_wait,
                              input bit mid_change, input logic [3:0] mid_cnt);
        logic [2:0] old_u;
        old_u = {3{model_mode}};
        for (int i = 0; i < drain_wait; i++) begin
            if (mid_change && i == 0) active_threads = mid_cnt;
            if (i == 1) xfer_ack = 1'b1;
            @(negedge clk);
            xfer_ack = 1'b0;
            chk(xfer_req == 1'b0, "R4 no request before drain", xfer_req, 0);
            chk(busy == 1'b1, "R3 busy during drain", busy, 1);
            chk(units() == old_u, "R5 stray ack in drain", units(), old_u);
        end
        pipe_empty = 1'b1;
        @(negedge clk);
        pipe_empty = 1'b0;
        chk(xfer_req && !xfer_fill, "R4 save request after drain", {xfer_req, xfer_fill}, 2);
        for (int i = 0; i < ack_wait; i++) begin
            @(negedge clk);
            chk(xfer_req && !xfer_fill, "R5 save request held", {xfer_req, xfer_fill}, 2);
            chk(units() == old_u, "R6 units stable during save", units(), old_u);
        end
        xfer_ack = 1'b1;
        @(negedge clk);
        xfer_ack = 1'b0;
        chk(units() == {3{tgt}}, "R6 units after save", units(), {3{tgt}});
        chk(!xfer_req && busy, "R6 units step no request", {xfer_req, busy}, 1);
        @(negedge clk);
        chk(xfer_req && xfer_fill, "R7 restore request", {xfer_req, xfer_fill}, 3);
        chk(rat_load == tgt, "R7 rename table load", rat_load, tgt);
        for (int i = 0; i < ack_wait; i++) begin
            @(negedge clk);
            chk(xfer_req && xfer_fill, "R5 restore request held", {xfer_req, xfer_fill}, 3);
            chk(mode_ooo == model_mode, "R3 mode unchanged before ack", mode_ooo, model_mode);
        end
        xfer_ack = 1'b1;
        @(negedge clk);
        xfer_ack = 1'b0;
        model_mode = tgt;
        chk(mode_ooo == tgt, "R8 mode after restore", mode_ooo, tgt);
        chk(busy == 1'b0 && xfer_req == 1'b0, "R8 busy falls", {busy, xfer_req}, 0);
    endtask

    // Applies a count from idle and checks whether a switch starts (R2).
    task automatic apply_count(input logic [3:0] c, input int dw, input int aw);
        logic tgt;
        tgt = (c <= 4'd2);
        active_threads = c;
        @(negedge clk);
        chk(busy == (tgt != model_mode), "R2 switch decision", busy, tgt != model_mode);
        if (busy) run_switch(tgt, dw, aw, 1'b0, 4'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(mode_ooo == 1'b1, "R1 reset mode", mode_ooo, 1);
        chk(units() == 3'b111, "R1 reset units", units(), 7);
        chk(!busy && !xfer_req, "R1 reset idle", {busy, xfer_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && mode_ooo, "R1 idle after reset", {busy, mode_ooo}, 1);

        // stray ack while idle
        xfer_ack = 1'b1;
        @(negedge clk);
        xfer_ack = 1'b0;
        @(negedge clk);
        chk(!busy && !xfer_req && mode_ooo && units() == 3'b111, "R5 idle ack ignored",
            {busy, xfer_req, mode_ooo}, 1);

        // sweep counts upward then downward from each mode
        for (int c = 0; c < 16; c++) apply_count(4'(c), 1 + (c % 3), c % 4);
        for (int c = 15; c >= 0; c--) apply_count(4'(c), 2, (c + 1) % 3);
        for (int c = 0; c < 16; c++) begin
            apply_count(4'(c), 1, 0);
            apply_count(4'd1, 1, 1);
        end

        // R9: count drops mid-switch to in-order; switch completes, then returns
        active_threads = 4'd6;
        @(negedge clk);
        chk(busy == 1'b1, "R9 switch start", busy, 1);
        run_switch(1'b0, 3, 2, 1'b1, 4'd2);
        @(negedge clk);
        chk(busy == 1'b1, "R9 re-evaluated after idle", busy, 1);
        run_switch(1'b1, 2, 1, 1'b1, 4'd3);
        @(negedge clk);
        chk(busy == 1'b1, "R9 second re-evaluation", busy, 1);
        run_switch(1'b0, 1, 0, 1'b1, 4'd7);
        @(negedge clk);
        chk(busy == 1'b0 && mode_ooo == 1'b0, "R9 stable when count agrees", {busy, mode_ooo}, 0);

        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule